// File: doc/BRIEF.md
# Privilege-Routed Indirect Register Decoder

This block sits between a hart's indirect register access path and a bank of interrupt-file pages. Each request carries the requesting privilege level, a virtualisation flag, a guest-file selector, an XLEN flag and an 8-bit select index. The block works out which page the request may reach and which register inside that page is meant: delivery control, priority threshold, the claim register, one of the pending words or one of the enable words. Legal requests are forwarded to the page side as a registered command. The page's read data is returned to the hart one cycle later. Illegal requests are never forwarded. They return zero data and raise a one-cycle illegal-access flag.

A parameter picks one of two configurations. In the machine configuration there is a single page, owned by machine mode. In the supervisor configuration, page 0 belongs to supervisor mode and pages 1 and above are guest files, reached only through virtualised accesses. The claim register has its own request strobe and does not use the select index.

Top module: `ireg_route`

## Requirements
- R1: With MMODE=1, a request is legal only when req_priv is 2'b11 (machine) and req_virt is 0, and it targets page 0. Every other privilege or virtualisation combination is illegal.
- R2: With MMODE=0, a request at req_priv 2'b01 (supervisor) with req_virt 0 targets page 0.
- R3: With MMODE=0, a supervisor request with req_virt 1 targets page req_guest. The request is illegal when req_guest is 0 or is not less than NUM_PAGES.
- R4: With MMODE=0, any req_priv other than 2'b01 (user 2'b00 or machine 2'b11) is illegal.
- R5: Select values decode as follows:
  - 8'h70 gives kind 0 (delivery) and 8'h72 gives kind 1 (threshold), both with word 0.
  - 8'h80 to 8'hBF give kind 3 (pending) with word number sel-8'h80.
  - 8'hC0 to 8'hFF give kind 4 (enable) with word number sel-8'hC0.
  - Every other select value is illegal.
- R6: When req_claim is 1, the request targets kind 2 (claim) with word 0, and req_sel is ignored.
- R7: When req_xlen64 is 1, an odd pending or enable word number is illegal, and an even one is halved to form fwd_word.
- R8: A pending or enable word index that is not less than N_IDS/32 (32-bit mode) or N_IDS/64 (64-bit mode) is illegal.
- R9: An illegal request produces the following, and nothing else:
  - no fwd_valid or fwd_we;
  - one edge later, nothing at the page side;
  - two edges after the request edge, rsp_illegal high for exactly one cycle, with rsp_valid 0 and rsp_rdata 0.
- R10: A legal request behaves as follows:
  - fwd_valid and the decoded fields appear one edge after the request edge.
  - fwd_we is 1 exactly when the effective write mask is nonzero.
  - In 32-bit mode, bits 63:32 of fwd_wdata and fwd_wmask are 0.
  - One edge later, rsp_valid is 1 and rsp_rdata carries page_rdata as sampled while fwd_valid was high.
- R11: After reset, fwd_valid, fwd_we, rsp_valid, rsp_illegal and rsp_rdata are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_claim | input | 1 | Request targets the claim register |
| req_priv | input | 2 | Requesting privilege (00 user, 01 supervisor, 11 machine) |
| req_virt | input | 1 | Virtualised access |
| req_guest | input | GUEST_W | Guest-file selector |
| req_xlen64 | input | 1 | 1 for 64-bit access, 0 for 32-bit |
| req_sel | input | SEL_W | Register select index |
| req_wdata | input | XW | New data |
| req_wmask | input | XW | Write mask |
| fwd_valid | output | 1 | Command to page side |
| fwd_page | output | PAGE_W | Target page |
| fwd_kind | output | 3 | Register kind |
| fwd_word | output | 6 | Word index within pending or enable array |
| fwd_wdata | output | XW | Forwarded new data |
| fwd_wmask | output | XW | Forwarded write mask |
| fwd_we | output | 1 | Forwarded write has a nonzero mask |
| page_rdata | input | XW | Read data from the selected page |
| rsp_valid | output | 1 | Legal response |
| rsp_rdata | output | XW | Read data back to the hart |
| rsp_illegal | output | 1 | One-cycle illegal-access flag |

## Verification
The bench builds two instances, both with N_IDS=128:
- A supervisor configuration with NUM_PAGES=4. With only four 32-bit words and two 64-bit words per array, the word-limit rejections sit a few select values above the base of each range. Guest selectors 0, 3 and 4 cover both bounds of the guest-page check.
- A machine configuration with NUM_PAGES=1. This covers the single-page privilege gate.

The page side is modelled as data computed from the forwarded page, kind and word. A returned response therefore shows both that routing was right and that the read path lines up in time.

// File: rtl/ireg_route_pkg.sv
package ireg_route_pkg;
  localparam int WORD_W = 6;

  typedef enum logic [2:0] {
    RK_DELIV  = 3'd0,
    RK_THRESH = 3'd1,
    RK_CLAIM  = 3'd2,
    RK_PEND   = 3'd3,
    RK_ENAB   = 3'd4
  } reg_kind_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam logic [7:0] SEL_DELIV  = 8'h70;
  localparam logic [7:0] SEL_THRESH = 8'h72;
  localparam logic [1:0] SEL_PEND_HI = 2'b10;
  localparam logic [1:0] SEL_ENAB_HI = 2'b11;
endpackage

// File: rtl/ireg_page_sel.sv
module ireg_page_sel
  import ireg_route_pkg::*;
#(
  parameter int MMODE     = 0,
  parameter int NUM_PAGES = 4,
  parameter int GUEST_W   = 6,
  parameter int PAGE_W    = 2
) (
  input  logic [1:0]         priv,
  input  logic               virt,
  input  logic [GUEST_W-1:0] guest,
  output logic               ok,
  output logic [PAGE_W-1:0]  page
);
  generate
    if (MMODE != 0) begin : g_mach
      // single page, machine mode only
      always_comb begin
        ok   = (priv == PRIV_M) && !virt;
        page = '0;
      end
    end else begin : g_sup
      logic guest_in_range;
      assign guest_in_range = (guest != '0) && (32'(guest) < 32'(NUM_PAGES));
      always_comb begin
        ok   = 1'b0;
        page = '0;
        if (priv == PRIV_S) begin
          if (virt) begin
            ok   = guest_in_range;
            page = guest_in_range ? PAGE_W'(guest) : '0;
          end else begin
            ok = 1'b1;
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ireg_index_dec.sv
module ireg_index_dec
  import ireg_route_pkg::*;
#(
  parameter int N_IDS = 256,
  parameter int SEL_W = 8
) (
  input  logic              claim,
  input  logic [SEL_W-1:0]  sel,
  input  logic              x64,
  output logic              ok,
  output reg_kind_e         kind,
  output logic [WORD_W-1:0] word
);
  localparam int WORDS32 = N_IDS / 32;
  localparam int WORDS64 = N_IDS / 64;

  logic [WORD_W-1:0] num;
  logic [WORD_W-1:0] widx;
  logic              word_ok;

  assign num  = sel[WORD_W-1:0];
  assign widx = x64 ? {1'b0, num[WORD_W-1:1]} : num;

  always_comb begin
    if (x64) word_ok = !num[0] && (32'(widx) < 32'(WORDS64));
    else     word_ok = 32'(widx) < 32'(WORDS32);
  end

  always_comb begin
    ok   = 1'b0;
    kind = RK_DELIV;
    word = '0;
    if (claim) begin
      ok   = 1'b1;
      kind = RK_CLAIM;
    end else if (sel == SEL_W'(SEL_DELIV)) begin
      ok   = 1'b1;
      kind = RK_DELIV;
    end else if (sel == SEL_W'(SEL_THRESH)) begin
      ok   = 1'b1;
      kind = RK_THRESH;
    end else if (sel[SEL_W-1:WORD_W] == (SEL_W-WORD_W)'(SEL_PEND_HI)) begin
      ok   = word_ok;
      kind = RK_PEND;
      word = widx;
    end else if (sel[SEL_W-1:WORD_W] == (SEL_W-WORD_W)'(SEL_ENAB_HI)) begin
      ok   = word_ok;
      kind = RK_ENAB;
      word = widx;
    end
  end
endmodule

// File: rtl/ireg_route.sv
module ireg_route
  import ireg_route_pkg::*;
#(
  parameter int MMODE     = 0,
  parameter int NUM_PAGES = 4,
  parameter int N_IDS     = 256,
  parameter int GUEST_W   = 6,
  parameter int SEL_W     = 8,
  parameter int XW        = 64,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_claim,
  input  logic [1:0]         req_priv,
  input  logic               req_virt,
  input  logic [GUEST_W-1:0] req_guest,
  input  logic               req_xlen64,
  input  logic [SEL_W-1:0]   req_sel,
  input  logic [XW-1:0]      req_wdata,
  input  logic [XW-1:0]      req_wmask,
  output logic               fwd_valid,
  output logic [PAGE_W-1:0]  fwd_page,
  output logic [2:0]         fwd_kind,
  output logic [WORD_W-1:0]  fwd_word,
  output logic [XW-1:0]      fwd_wdata,
  output logic [XW-1:0]      fwd_wmask,
  output logic               fwd_we,
  input  logic [XW-1:0]      page_rdata,
  output logic               rsp_valid,
  output logic [XW-1:0]      rsp_rdata,
  output logic               rsp_illegal
);
  localparam int HALF = XW / 2;

  logic              page_ok, idx_ok, legal;
  logic [PAGE_W-1:0] dec_page;
  reg_kind_e         dec_kind;
  logic [WORD_W-1:0] dec_word;
  logic [XW-1:0]     eff_wdata, eff_wmask;
  logic              ill_s1;

  ireg_page_sel #(
    .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .GUEST_W(GUEST_W), .PAGE_W(PAGE_W)
  ) u_page (
    .priv(req_priv), .virt(req_virt), .guest(req_guest),
    .ok(page_ok), .page(dec_page)
  );

  ireg_index_dec #(.N_IDS(N_IDS), .SEL_W(SEL_W)) u_index (
    .claim(req_claim), .sel(req_sel), .x64(req_xlen64),
    .ok(idx_ok), .kind(dec_kind), .word(dec_word)
  );

  assign legal     = page_ok && idx_ok;
  assign eff_wdata = req_xlen64 ? req_wdata : {{HALF{1'b0}}, req_wdata[HALF-1:0]};
  assign eff_wmask = req_xlen64 ? req_wmask : {{HALF{1'b0}}, req_wmask[HALF-1:0]};

  // command stage
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_we    <= 1'b0;
      fwd_page  <= '0;
      fwd_kind  <= '0;
      fwd_word  <= '0;
      fwd_wdata <= '0;
      fwd_wmask <= '0;
      ill_s1    <= 1'b0;
    end else begin
      fwd_valid <= req_valid && legal;
      fwd_we    <= req_valid && legal && (eff_wmask != '0);
      ill_s1    <= req_valid && !legal;
      if (req_valid && legal) begin
        fwd_page  <= dec_page;
        fwd_kind  <= dec_kind;
        fwd_word  <= dec_word;
        fwd_wdata <= eff_wdata;
        fwd_wmask <= eff_wmask;
      end else begin
        fwd_page  <= '0;
        fwd_kind  <= '0;
        fwd_word  <= '0;
        fwd_wdata <= '0;
        fwd_wmask <= '0;
      end
    end
  end

  // response stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_illegal <= 1'b0;
    end else begin
      rsp_valid   <= fwd_valid;
      rsp_rdata   <= fwd_valid ? page_rdata : '0;
      rsp_illegal <= ill_s1;
    end
  end
endmodule

// File: rtl/ireg_route_chk.sv
module ireg_route_chk #(
  parameter int MMODE     = 0,
  parameter int NUM_PAGES = 4,
  parameter int XW        = 64,
  parameter int PAGE_W    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_virt,
  input logic              fwd_valid,
  input logic [PAGE_W-1:0] fwd_page,
  input logic [XW-1:0]     fwd_wmask,
  input logic              fwd_we,
  input logic              rsp_valid,
  input logic [XW-1:0]     rsp_rdata,
  input logic              rsp_illegal
);
  // R9
  ill_rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (rsp_rdata == '0) && !rsp_valid);
  // R9
  no_spurious_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> !fwd_valid);
  // R10
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |=> rsp_valid);
  // R10
  we_needs_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_we |-> fwd_valid && (fwd_wmask != '0));
  // R1
  page_range_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> (32'(fwd_page) < 32'(NUM_PAGES)) && (MMODE == 0 || fwd_page == '0));
  // R3
  guest_page_chk: assert property (@(posedge clk) disable iff (rst)
    (fwd_valid && fwd_page != '0) |-> $past(req_virt));
endmodule

bind ireg_route ireg_route_chk #(
  .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .XW(XW), .PAGE_W(PAGE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_virt(req_virt),
  .fwd_valid(fwd_valid), .fwd_page(fwd_page), .fwd_wmask(fwd_wmask),
  .fwd_we(fwd_we), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_illegal(rsp_illegal)
);

// File: tb/ireg_route_bench.sv
module ireg_route_bench;
  localparam int N_IDS = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        vld_s = 1'b0, vld_m = 1'b0, claim = 1'b0, virt = 1'b0, x64 = 1'b0;
  logic [1:0]  priv = 2'b00;
  logic [5:0]  guest = '0;
  logic [7:0]  sel = '0;
  logic [63:0] wdata = '0, wmask = '0;

  logic        fv_s, we_s, rv_s, ri_s, fv_m, we_m, rv_m, ri_m;
  logic [1:0]  pg_s;
  logic [0:0]  pg_m;
  logic [2:0]  kd_s, kd_m;
  logic [5:0]  wd_s, wd_m;
  logic [63:0] fwdat_s, fwm_s, rd_s, prd_s, fwdat_m, fwm_m, rd_m, prd_m;

  function automatic logic [63:0] pr(logic [2:0] k, logic [5:0] w, logic [1:0] p, logic [63:0] d);
    return {d[31:0] ^ 32'h1234_5678, 14'h2A5A, p, 5'b0, k, 2'b0, w};
  endfunction

  assign prd_s = pr(kd_s, wd_s, pg_s, fwdat_s);
  assign prd_m = pr(kd_m, wd_m, {1'b0, pg_m}, fwdat_m);

  ireg_route #(.MMODE(0), .NUM_PAGES(4), .N_IDS(N_IDS)) u_ireg_route (
    .clk(clk), .rst(rst), .req_valid(vld_s), .req_claim(claim), .req_priv(priv),
    .req_virt(virt), .req_guest(guest), .req_xlen64(x64), .req_sel(sel),
    .req_wdata(wdata), .req_wmask(wmask), .fwd_valid(fv_s), .fwd_page(pg_s),
    .fwd_kind(kd_s), .fwd_word(wd_s), .fwd_wdata(fwdat_s), .fwd_wmask(fwm_s),
    .fwd_we(we_s), .page_rdata(prd_s), .rsp_valid(rv_s), .rsp_rdata(rd_s),
    .rsp_illegal(ri_s));

  ireg_route #(.MMODE(1), .NUM_PAGES(1), .N_IDS(N_IDS)) u_ireg_route_mach (
    .clk(clk), .rst(rst), .req_valid(vld_m), .req_claim(claim), .req_priv(priv),
    .req_virt(virt), .req_guest(guest), .req_xlen64(x64), .req_sel(sel),
    .req_wdata(wdata), .req_wmask(wmask), .fwd_valid(fv_m), .fwd_page(pg_m),
    .fwd_kind(kd_m), .fwd_word(wd_m), .fwd_wdata(fwdat_m), .fwd_wmask(fwm_m),
    .fwd_we(we_m), .page_rdata(prd_m), .rsp_valid(rv_m), .rsp_rdata(rd_m),
    .rsp_illegal(ri_m));

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic       mm;
    logic [1:0] priv;
    logic       virt;
    logic [5:0] guest;
    logic       x64;
    logic       claim;
    logic [7:0] sel;
    logic       ok;
    logic [1:0] page;
    logic [2:0] kind;
    logic [5:0] word;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'b11, 1'b0, 6'd0, 1'b0, 1'b0, 8'h70, 1'b1, 2'd0, 3'd0, 6'd0, 4'd1},  // R1
    '{1'b1, 2'b11, 1'b1, 6'd0, 1'b0, 1'b0, 8'h70, 1'b0, 2'd0, 3'd0, 6'd0, 4'd1},  // R1 virt
    '{1'b1, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'h72, 1'b0, 2'd0, 3'd0, 6'd0, 4'd1},  // R1 S-priv
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'h72, 1'b1, 2'd0, 3'd1, 6'd0, 4'd2},  // R2
    '{1'b0, 2'b01, 1'b1, 6'd2, 1'b0, 1'b0, 8'h83, 1'b1, 2'd2, 3'd3, 6'd3, 4'd3},  // R3
    '{1'b0, 2'b01, 1'b1, 6'd0, 1'b0, 1'b0, 8'h70, 1'b0, 2'd0, 3'd0, 6'd0, 4'd3},  // R3 guest 0
    '{1'b0, 2'b01, 1'b1, 6'd4, 1'b0, 1'b0, 8'h70, 1'b0, 2'd0, 3'd0, 6'd0, 4'd3},  // R3 guest 4
    '{1'b0, 2'b01, 1'b1, 6'd3, 1'b0, 1'b0, 8'hC1, 1'b1, 2'd3, 3'd4, 6'd1, 4'd3},  // R3 top guest
    '{1'b0, 2'b11, 1'b0, 6'd0, 1'b0, 1'b0, 8'h70, 1'b0, 2'd0, 3'd0, 6'd0, 4'd4},  // R4 machine
    '{1'b0, 2'b00, 1'b0, 6'd0, 1'b0, 1'b0, 8'h70, 1'b0, 2'd0, 3'd0, 6'd0, 4'd4},  // R4 user
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'h71, 1'b0, 2'd0, 3'd0, 6'd0, 4'd5},  // R5 hole
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'h6F, 1'b0, 2'd0, 3'd0, 6'd0, 4'd5},  // R5 below
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'hC2, 1'b1, 2'd0, 3'd4, 6'd2, 4'd5},  // R5 enable
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b1, 8'h00, 1'b1, 2'd0, 3'd2, 6'd0, 4'd6},  // R6
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b1, 1'b0, 8'h81, 1'b0, 2'd0, 3'd0, 6'd0, 4'd7},  // R7 odd
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b1, 1'b0, 8'hC2, 1'b1, 2'd0, 3'd4, 6'd1, 4'd7},  // R7 halve
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'h84, 1'b0, 2'd0, 3'd0, 6'd0, 4'd8},  // R8 32-bit
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b1, 1'b0, 8'h84, 1'b0, 2'd0, 3'd0, 6'd0, 4'd8},  // R8 64-bit
    '{1'b0, 2'b01, 1'b0, 6'd0, 1'b0, 1'b0, 8'hBF, 1'b0, 2'd0, 3'd0, 6'd0, 4'd8},  // R8 top
    '{1'b1, 2'b11, 1'b0, 6'd0, 1'b1, 1'b0, 8'h82, 1'b1, 2'd0, 3'd3, 6'd1, 4'd7}   // R7 machine
  };

  // drive one request, check the command stage and then the response stage
  task automatic run(input vec_t v, input logic [63:0] d, input logic [63:0] m);
    string tg;
    logic [63:0] em, ed;
    logic f_v, f_we, r_v, r_i;
    logic [1:0] f_p;
    logic [2:0] f_k;
    logic [5:0] f_w;
    logic [63:0] f_m, f_d, r_d;
    tg = $sformatf("R%0d", v.req);
    @(negedge clk);
    priv = v.priv; virt = v.virt; guest = v.guest; x64 = v.x64;
    claim = v.claim; sel = v.sel; wdata = d; wmask = m;
    vld_m = v.mm; vld_s = !v.mm;
    @(negedge clk);
    vld_m = 1'b0; vld_s = 1'b0;
    if (v.mm) begin
      f_v = fv_m; f_we = we_m; f_p = {1'b0, pg_m}; f_k = kd_m; f_w = wd_m; f_m = fwm_m; f_d = fwdat_m;
    end else begin
      f_v = fv_s; f_we = we_s; f_p = pg_s; f_k = kd_s; f_w = wd_s; f_m = fwm_s; f_d = fwdat_s;
    end
    em = v.x64 ? m : {32'h0, m[31:0]};
    ed = v.x64 ? d : {32'h0, d[31:0]};
    chk({tg, " fwd_valid"}, 64'(f_v), 64'(v.ok));
    chk({tg, " fwd_we"}, 64'(f_we), 64'(v.ok && em != 0));
    if (v.ok) begin
      chk({tg, " page"}, 64'(f_p), 64'(v.page));
      chk({tg, " kind"}, 64'(f_k), 64'(v.kind));
      chk({tg, " word"}, 64'(f_w), 64'(v.word));
      chk("R10 wmask", f_m, em);
      chk("R10 wdata", f_d, ed);
    end
    @(negedge clk);
    if (v.mm) begin r_v = rv_m; r_i = ri_m; r_d = rd_m; end
    else      begin r_v = rv_s; r_i = ri_s; r_d = rd_s; end
    chk({tg, " R10 rsp_valid"}, 64'(r_v), 64'(v.ok));
    chk({tg, " R9 rsp_illegal"}, 64'(r_i), 64'(!v.ok));
    chk({tg, " rsp_rdata"}, r_d, v.ok ? pr(v.kind, v.word, v.page, ed) : 64'h0);
    @(negedge clk);
    chk("R9 illegal pulse width", 64'(v.mm ? ri_m : ri_s), 64'h0);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 fwd_valid", 64'(fv_s | fv_m), 64'h0);
    chk("R11 fwd_we", 64'(we_s | we_m), 64'h0);
    chk("R11 rsp_valid", 64'(rv_s | rv_m), 64'h0);
    chk("R11 rsp_illegal", 64'(ri_s | ri_m), 64'h0);
    chk("R11 rsp_rdata", rd_s | rd_m, 64'h0);

    for (int i = 0; i < NV; i++)
      run(VECS[i], 64'hDEAD_BEEF_0123_4500 + 64'(i), 64'hFFFF_FFFF_FFFF_FFFF);

    // R10: mask with only upper bits in 32-bit mode is empty, no write
    run(VECS[3], 64'hCAFE_0000_0000_0042, 64'hFFFF_0000_0000_0000);
    // R10: zero mask in 64-bit mode, no write
    run(VECS[15], 64'h0123_4567_89AB_CDEF, 64'h0);
    // R6: claim with a select that would otherwise be illegal
    run('{1'b0, 2'b01, 1'b1, 6'd1, 1'b1, 1'b1, 8'h71, 1'b1, 2'd1, 3'd2, 6'd0, 4'd6},
        64'h1111_2222_3333_4444, 64'h1);
    // R3: largest guest selector, also out of range
    run('{1'b0, 2'b01, 1'b1, 6'd63, 1'b0, 1'b0, 8'h80, 1'b0, 2'd0, 3'd0, 6'd0, 4'd3},
        64'h5, 64'h5);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule